// File: doc/BRIEF.md
# Four-Phase Handshake Sequencer

This block links two return-to-zero handshake channels. On its left side it is passive: a requester raises `lreq_i` and waits for `lack_o`. On its right side it is active: it raises `rreq_o` and waits for `rack_i`. Each left request starts exactly one complete right handshake. That handshake has request up, acknowledge up, request down and acknowledge down. Only after the right side is back to idle does the block acknowledge the left side. The left side then withdraws its request and the acknowledge drops.

The controller is built as a clocked, sampled circuit. Both incoming handshake wires pass through a multi-flop synchroniser before the logic sees them, and all three state elements are flops. These are the two outputs and one internal phase bit. The phase bit records that the right handshake has been answered. With it, every point of the cycle has its own code, so the condition that drops the right request never overlaps the condition that raises it.

Top module: `hs_seq_ctrl`

## Requirements
- R1: While `rst_ni` is low at a rising clock edge, `rreq_o`, `lack_o` and the internal phase bit become 0. With both inputs low afterwards, both outputs stay 0.
- R2: With the phase bit clear, a rise of `lreq_i` raises `rreq_o` on the third rising clock edge after the input change, with the default two-stage synchroniser.
- R3: A rise of `rack_i` sets the phase bit on the third rising edge after the change, and `rreq_o` falls on the fourth.
- R4: With the phase bit set, a fall of `rack_i` raises `lack_o` on the third rising edge after the change.
- R5: A fall of `lreq_i` clears the phase bit on the third rising edge after the change, and `lack_o` falls on the fourth.
- R6: `rreq_o` and `lack_o` are never high together.
- R7: Across many cycles with varying environment delays, the wire events occur in this exact repeating order: lreq up, rreq up, rack up, rreq down, rack down, lack up, lreq down, lack down.
- R8: While the phase bit is set and `lreq_i` stays high, `rreq_o` stays low and `lack_o` stays high, however long the left request is held.
- R9: The environment may drop `lreq_i` only while `lack_o` is high. It may raise `rack_i` only while `rreq_o` is high, and drop it only while `rreq_o` is low. A breach is reported as a protocol error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| lreq_i | input | 1 | Left-channel request from the upstream requester |
| lack_o | output | 1 | Left-channel acknowledge |
| rreq_o | output | 1 | Right-channel request to the downstream responder |
| rack_i | input | 1 | Right-channel acknowledge from the downstream responder |

## Verification
Each input change passes through two synchroniser flops, and the outputs then respond as follows:
- Outputs driven straight from a synchronised input change on the third rising edge after the input change: `rreq_o` rising and `lack_o` rising.
- Outputs that must wait for the phase bit to update first change on the fourth edge: `rreq_o` falling and `lack_o` falling.

The bench drives its inputs 2 ns after a rising edge and samples on falling edges, counting falling edges from the drive point. The first falling edge comes before any rising edge. A three-edge result is therefore expected at count 4 and a four-edge result at count 5, and the timed tests compare those exact counts. Untimed runs with random delays wait on each output with a bound and check the global event order seen at the falling-edge samples.

// File: rtl/hsq_pkg.sv
// Shared constants and types for the four-phase handshake sequencer.
package hsq_pkg;
    // Default number of synchroniser flops on each handshake input.
    localparam int unsigned SYNC_DEPTH_DEF = 2;

    // Synchronised view of the two incoming handshake wires.
    typedef struct packed {
        logic lreq;
        logic rack;
    } hsq_in_t;

    localparam int unsigned HSQ_IN_W = $bits(hsq_in_t);
endpackage

// File: rtl/hsq_sync.sv
// Multi-stage flop synchroniser for a bundle of independent single-bit
// signals. Assumes each bit is a level that stays stable long enough to be
// seen; no bits are correlated. Reset clears every stage.
module hsq_sync #(
    parameter int unsigned WIDTH = 2,
    parameter int unsigned DEPTH = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    localparam int unsigned LAST = DEPTH - 1;

    logic [WIDTH-1:0] stage_q [DEPTH];

    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage captures the asynchronous inputs.
                always_ff @(posedge clk_i) begin
                    if (!rst_ni) stage_q[s] <= '0;
                    else         stage_q[s] <= d_i;
                end
            end else begin : g_next
                // Later stages let a metastable first stage settle.
                always_ff @(posedge clk_i) begin
                    if (!rst_ni) stage_q[s] <= '0;
                    else         stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[LAST];
endmodule

// File: rtl/hsq_core.sv
// Sequencing core. Works on already synchronised inputs and holds three
// flops: the right request, the left acknowledge and a phase bit. The phase
// bit is set once the right side has acknowledged. It is cleared once the
// left request is withdrawn. Assumes a four-phase compliant environment.
module hsq_core (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lreq_s_i,
    input  logic rack_s_i,
    output logic rreq_o,
    output logic lack_o,
    output logic phase_o
);
    logic phase_q;
    logic rreq_q;
    logic lack_q;
    logic phase_d;
    logic rreq_d;
    logic lack_d;

    // Next-state terms: the phase bit holds while the left request stays up.
    always_comb begin
        phase_d = lreq_s_i & (rack_s_i | phase_q);
        rreq_d  = lreq_s_i & ~phase_q;
        lack_d  = phase_q  & ~rack_s_i;
    end

    // State and output registers, cleared by reset.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            phase_q <= 1'b0;
            rreq_q  <= 1'b0;
            lack_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            rreq_q  <= rreq_d;
            lack_q  <= lack_d;
        end
    end

    assign rreq_o  = rreq_q;
    assign lack_o  = lack_q;
    assign phase_o = phase_q;
endmodule

// File: rtl/hs_seq_ctrl.sv
// Top level of the four-phase handshake sequencer. Synchronises the left
// request and right acknowledge, then runs the sequencing core. Outputs come
// straight from flops, so they cannot glitch.
module hs_seq_ctrl #(
    parameter int unsigned SYNC_DEPTH = hsq_pkg::SYNC_DEPTH_DEF
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lreq_i,
    output logic lack_o,
    output logic rreq_o,
    input  logic rack_i
);
    import hsq_pkg::*;

    hsq_in_t raw_w;
    hsq_in_t syn_w;
    logic    phase_w;

    // Bundle the raw asynchronous inputs.
    always_comb begin
        raw_w.lreq = lreq_i;
        raw_w.rack = rack_i;
    end

    hsq_sync #(
        .WIDTH (HSQ_IN_W),
        .DEPTH (SYNC_DEPTH)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (raw_w),
        .q_o    (syn_w)
    );

    hsq_core u_core (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .lreq_s_i (syn_w.lreq),
        .rack_s_i (syn_w.rack),
        .rreq_o   (rreq_o),
        .lack_o   (lack_o),
        .phase_o  (phase_w)
    );
endmodule

// File: rtl/hs_seq_ctrl_chk.sv
// Protocol checker for the handshake sequencer, bound to the top level.
// Observes the ports and the internal phase bit.
module hs_seq_ctrl_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic lreq_i,
    input logic lack_o,
    input logic rreq_o,
    input logic rack_i,
    input logic phase
);
    AST_IDLE_AFTER_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(!rst_ni) |-> (!rreq_o && !lack_o && !phase)); // R1
    AST_RREQ_RISE_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rreq_o) |-> (!phase && !lack_o)); // R2
    AST_LACK_RISE_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(lack_o) |-> (phase && !rreq_o)); // R4
    AST_LACK_FALL_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(lack_o) |-> !phase); // R5
    AST_NO_BOTH_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rreq_o && lack_o)); // R6
    AST_LREQ_DROP_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(lreq_i) |-> lack_o); // R9
    AST_RACK_RISE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rack_i) |-> rreq_o); // R9
    AST_RACK_FALL_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(rack_i) |-> !rreq_o); // R9
endmodule

bind hs_seq_ctrl hs_seq_ctrl_chk u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lreq_i (lreq_i),
    .lack_o (lack_o),
    .rreq_o (rreq_o),
    .rack_i (rack_i),
    .phase  (phase_w)
);

// File: tb/hs_seq_ctrl_test.sv
// Directed bench for the handshake sequencer: one task per scenario.
module hs_seq_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic li = 1'b0;
    logic ri = 1'b0;
    logic lo;
    logic ro;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit mon_en = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    hs_seq_ctrl uut (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .lreq_i (li),
        .lack_o (lo),
        .rreq_o (ro),
        .rack_i (ri)
    );

    // Expected event order (R7): wire id 0=lreq 1=rreq 2=rack 3=lack.
    localparam int EID[8] = '{0, 1, 2, 1, 2, 3, 0, 3};
    localparam bit EVAL[8] = '{1, 1, 1, 0, 0, 1, 0, 0};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Event-order monitor, sampled on falling edges (R7, R6).
    int  ev_idx = 0;
    logic [3:0] prev_w = '0;
    always @(negedge clk) begin
        logic [3:0] now_w;
        now_w = {lo, ri, ro, li};
        if (mon_en) begin
            for (int k = 0; k < 4; k++) begin
                if (now_w[k] != prev_w[k]) begin
                    chk(k == EID[ev_idx] && now_w[k] == EVAL[ev_idx], "R7 event order",
                        k * 10 + int'(now_w[k]), EID[ev_idx] * 10 + int'(EVAL[ev_idx]));
                    ev_idx = (ev_idx + 1) % 8;
                end
            end
            if (ro && lo) chk(1'b0, "R6 rreq and lack both high", 1, 0);
        end
        prev_w = now_w;
    end

    // Count falling edges until the chosen output (1=rreq, 3=lack) reaches val.
    task automatic wait_out(input int which, input logic val, output int n);
        logic cur;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            cur = (which == 1) ? ro : lo;
        end while (cur != val && n < 60);
    endtask

    task automatic drive_after(input int d);
        repeat (d) @(posedge clk);
        @(posedge clk);
        #2;
    endtask

    // One full left/right handshake; timed runs check exact latencies.
    task automatic run_hs(input int d_up, input int d_dn, input int d_lo,
                          input int d_next, input bit timed, input int hold);
        int n;
        drive_after(d_next);
        li = 1'b1;
        wait_out(1, 1'b1, n);
        if (timed) chk(n == 4, "R2 rreq rise latency", n, 4);
        else       chk(n < 60, "R7 rreq rise reached", n, 0);
        drive_after(d_up);
        ri = 1'b1;
        wait_out(1, 1'b0, n);
        if (timed) chk(n == 5, "R3 rreq fall latency", n, 5);
        else       chk(n < 60, "R7 rreq fall reached", n, 0);
        drive_after(d_dn);
        ri = 1'b0;
        wait_out(3, 1'b1, n);
        if (timed) chk(n == 4, "R4 lack rise latency", n, 4);
        else       chk(n < 60, "R7 lack rise reached", n, 0);
        if (hold > 0) begin
            bit bad = 1'b0;
            for (int c = 0; c < hold; c++) begin
                @(negedge clk);
                if (ro || !lo) bad = 1'b1;
            end
            chk(!bad, "R8 rreq low and lack high while held", int'(bad), 0);
        end
        drive_after(d_lo);
        li = 1'b0;
        wait_out(3, 1'b0, n);
        if (timed) chk(n == 5, "R5 lack fall latency", n, 5);
        else       chk(n < 60, "R7 lack fall reached", n, 0);
    endtask

    task automatic t_reset;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(!ro && !lo, "R1 outputs low in reset", {ro, lo}, 0);
        @(posedge clk); #2; rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(!ro && !lo, "R1 outputs idle after reset", {ro, lo}, 0);
    endtask

    task automatic t_timed;
        run_hs(0, 0, 0, 0, 1'b1, 0);
        run_hs(3, 5, 2, 4, 1'b1, 0);
    endtask

    task automatic t_hold;
        run_hs(1, 1, 0, 2, 1'b0, 25);
    endtask

    task automatic t_random;
        for (int i = 0; i < 150; i++)
            run_hs($urandom_range(0, 6), $urandom_range(0, 6),
                   $urandom_range(0, 6), $urandom_range(0, 6), 1'b0, 0);
        @(negedge clk);
        chk(ev_idx == 0, "R7 event count whole cycles", ev_idx, 0);
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        void'($urandom(17));
        t_reset();
        mon_en = 1'b1;
        t_timed();
        t_hold();
        t_random();
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog expired", 0, 1);
            report();
            $finish;
        end
    end
endmodule